// File: doc/BRIEF.md
# Synchronous DRAM Read Return Pipeline

This block lives inside a synchronous DRAM controller, between the raw data pins and the user read port. Each time the controller issues a column read, it also pulses `rd_issue` with a small tag. The block carries that tag and a valid bit down a short shift pipeline. When the programmed read latency of two or three clocks has passed, it samples the 16-bit data bus at the moment the word arrives. It then presents the word, the tag and a valid flag on a registered capture port.

Byte masks asserted during a read cause the memory to float the masked byte lanes two clocks later. This delay is fixed and does not depend on the read latency. The block delays the mask bits along their own two-stage path and reports each masked lane with its byte-valid flag cleared. The beat itself is still delivered, so the beat count matches the number of reads issued. A new read may be issued on every clock, so the pipeline accepts back-to-back reads and interrupted bursts without gaps. The latency setting is adopted only while no read is in flight.

Top module: `rdq_latency_pipe`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cap_valid`, `cap_tag`, `cap_data` and `cap_byte_vld` are all zero, whatever `rd_issue`, `dqm` and `dq_in` do.
- R2: With latency two in effect (`lat_cfg` = 0), a read issued in cycle c produces `cap_valid` = 1 with `cap_tag` equal to that read's tag in cycle c+3.
- R3: With latency three in effect (`lat_cfg` = 1), a read issued in cycle c produces `cap_valid` = 1 with its tag in cycle c+4.
- R4: Reads issued on consecutive clocks each produce exactly one capture, one per clock, in issue order, with no gaps.
- R5: A `dqm` bit high in cycle m clears the matching `cap_byte_vld` bit for the beat on `dq_in` in cycle m+2, under either latency. Bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A byte-valid bit is 1 only when the beat is valid and its lane is unmasked.
- R6: A masked beat is still reported with `cap_valid` = 1. The masked lane of `cap_data` reads zero.
- R7: For a read issued in cycle c with latency L, the unmasked lanes of `cap_data` in cycle c+L+1 equal `dq_in` as driven in cycle c+L.
- R8: A new `lat_cfg` value takes effect only at the end of a cycle in which no read is issued and no read issued in the previous three cycles is still in flight. Reads already in flight keep the latency in effect when they were issued.
- R9: In a cycle with no returning read, `cap_valid`, `cap_byte_vld` and `cap_data` are zero, even while `dq_in` and `dqm` toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_issue | input | 1 | High in the cycle a column read goes to the memory |
| rd_tag | input | TAG_W | Identifier carried with the read |
| lat_cfg | input | 1 | Read latency setting: 0 selects two clocks, 1 selects three |
| dqm | input | DATA_W/8 | Byte mask bits as driven to the memory this cycle |
| dq_in | input | DATA_W | Raw data bus from the memory |
| cap_valid | output | 1 | A returned beat is presented this cycle |
| cap_tag | output | TAG_W | Tag of the presented beat |
| cap_data | output | DATA_W | Captured word, with masked lanes set to zero |
| cap_byte_vld | output | DATA_W/8 | Per-lane valid flags of the presented beat |

## Verification
A stage of the issue shift register that drops or duplicates an entry shows up at the capture port within four cycles of the affected read. It appears as a missing, extra or mistagged `cap_valid` pulse. A mask path with the wrong depth shifts the cleared byte-valid flags one beat early or late, and this is visible in the cycle the beat is captured. A latency register that changes while reads are in flight moves those captures to the wrong cycle. Free-running dense traffic under both latencies catches every one of these faults at the next return.

// File: rtl/rdq_pipe_pkg.sv
package rdq_pipe_pkg;

    typedef enum logic {
        LAT_TWO   = 1'b0,
        LAT_THREE = 1'b1
    } rd_lat_e;

    localparam int unsigned LAT_MAX = 3;

    function automatic int unsigned lat_clocks(rd_lat_e l);
        return (l == LAT_THREE) ? 3 : 2;
    endfunction

endpackage

// File: rtl/rdq_issue_shift.sv
module rdq_issue_shift #(
    parameter int unsigned TAG_W = 4,
    parameter int unsigned DEPTH = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            issue,
    input  logic [TAG_W-1:0]                tag,
    output logic [DEPTH-1:0]                vld_o,
    output logic [DEPTH-1:0][TAG_W-1:0]     tag_o
);

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d        = sh_q;
        sh_d.vld[0] = issue;
        sh_d.tag[0] = issue ? tag : '0;
        for (int k = 1; k < DEPTH; k++) begin
            sh_d.vld[k] = sh_q.vld[k-1];
            sh_d.tag[k] = sh_q.tag[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign vld_o = sh_q.vld;
    assign tag_o = sh_q.tag;

    // R4: every issue enters the first stage with its tag
    p_issue_enters_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (vld_o[0] && tag_o[0] == $past(tag)));

    generate
        for (genvar k = 0; k < DEPTH - 1; k++) begin : g_adv
            // R4: no entry is lost or retagged between stages
            p_stage_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
                vld_o[k] |=> (vld_o[k+1] && tag_o[k+1] == $past(tag_o[k])));
        end
    endgenerate

endmodule

// File: rtl/rdq_mask_delay.sv
module rdq_mask_delay #(
    parameter int unsigned BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BYTES-1:0] mask_i,
    output logic [BYTES-1:0] mask_o
);

    localparam int unsigned DLY = 2;

    typedef struct packed {
        logic [DLY-1:0][BYTES-1:0] st;
    } mdly_t;

    mdly_t md_d, md_q;

    always_comb begin
        md_d       = md_q;
        md_d.st[0] = mask_i;
        for (int k = 1; k < DLY; k++) begin
            md_d.st[k] = md_q.st[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) md_q <= '0;
        else        md_q <= md_d;
    end

    assign mask_o = md_q.st[DLY-1];

    // R5: lane mask reaches the capture stage exactly two clocks after it is driven
    p_mask_two_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (mask_o == $past(mask_i, 2)));

endmodule

// File: rtl/rdq_latency_pipe.sv
module rdq_latency_pipe
    import rdq_pipe_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned TAG_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_issue,
    input  logic [TAG_W-1:0]      rd_tag,
    input  logic                  lat_cfg,
    input  logic [DATA_W/8-1:0]   dqm,
    input  logic [DATA_W-1:0]     dq_in,
    output logic                  cap_valid,
    output logic [TAG_W-1:0]      cap_tag,
    output logic [DATA_W-1:0]     cap_data,
    output logic [DATA_W/8-1:0]   cap_byte_vld
);

    localparam int unsigned BYTES = DATA_W / 8;
    localparam int unsigned DEPTH = LAT_MAX;

    typedef struct packed {
        rd_lat_e             lat;
        logic                valid;
        logic [TAG_W-1:0]    tag;
        logic [DATA_W-1:0]   data;
        logic [BYTES-1:0]    bvld;
    } cap_t;

    cap_t cp_d, cp_q;

    logic [DEPTH-1:0]            stg_vld;
    logic [DEPTH-1:0][TAG_W-1:0] stg_tag;
    logic [BYTES-1:0]            lane_mask;
    logic                        busy;
    logic                        hit;
    logic [TAG_W-1:0]            hit_tag;

    rdq_issue_shift #(
        .TAG_W (TAG_W),
        .DEPTH (DEPTH)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (rd_issue),
        .tag   (rd_tag),
        .vld_o (stg_vld),
        .tag_o (stg_tag)
    );

    rdq_mask_delay #(
        .BYTES (BYTES)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (dqm),
        .mask_o (lane_mask)
    );

    assign busy = |stg_vld;

    always_comb begin
        cp_d = cp_q;
        if (!busy && !rd_issue) begin
            cp_d.lat = rd_lat_e'(lat_cfg);
        end
        if (cp_q.lat == LAT_THREE) begin
            hit     = stg_vld[2];
            hit_tag = stg_tag[2];
        end else begin
            hit     = stg_vld[1];
            hit_tag = stg_tag[1];
        end
        cp_d.valid = hit;
        cp_d.tag   = hit ? hit_tag : '0;
        for (int b = 0; b < BYTES; b++) begin
            cp_d.bvld[b]         = hit && !lane_mask[b];
            cp_d.data[b*8 +: 8]  = cp_d.bvld[b] ? dq_in[b*8 +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cp_q <= '{lat: LAT_TWO, valid: 1'b0, tag: '0, data: '0, bvld: '0};
        else        cp_q <= cp_d;
    end

    assign cap_valid    = cp_q.valid;
    assign cap_tag      = cp_q.tag;
    assign cap_data     = cp_q.data;
    assign cap_byte_vld = cp_q.bvld;

    // R8: latency setting never moves while a read is in flight
    p_lat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || rd_issue) |=> $stable(cp_q.lat));

    // R2: a latency-two capture traces back to an issue three clocks earlier
    p_cap_lat2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && cap_valid && cp_q.lat == LAT_TWO) |-> $past(rd_issue, 3));

    // R3: a latency-three capture traces back to an issue four clocks earlier
    p_cap_lat3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 4) && cap_valid && cp_q.lat == LAT_THREE) |-> $past(rd_issue, 4));

    // R5: a lane masked three clocks ago is never flagged valid now
    p_mask_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 3) |-> ((cap_byte_vld & $past(dqm, 3)) == '0));

    // R9: no lane is valid and no data is shown without a beat
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |-> (cap_byte_vld == '0 && cap_data == '0));

endmodule

// File: tb/rdq_latency_pipe_tb.sv
`timescale 1ns/1ps
module rdq_latency_pipe_tb;

    localparam int NC = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_issue = 1'b0;
    logic [3:0]  rd_tag = '0;
    logic        lat_cfg = 1'b0;
    logic [1:0]  dqm = '0;
    logic [15:0] dq_in = '0;
    logic        cap_valid;
    logic [3:0]  cap_tag;
    logic [15:0] cap_data;
    logic [1:0]  cap_byte_vld;

    always #2.5 clk = ~clk;

    rdq_latency_pipe #(.DATA_W(16), .TAG_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .rd_tag(rd_tag),
        .lat_cfg(lat_cfg), .dqm(dqm), .dq_in(dq_in), .cap_valid(cap_valid),
        .cap_tag(cap_tag), .cap_data(cap_data), .cap_byte_vld(cap_byte_vld)
    );

    int nchk = 0;
    int nerr = 0;
    int n    = 0;
    logic [31:0] rng = 32'h1234_5678;
    bit   done = 1'b0;

    logic        iss_a [NC];
    logic [3:0]  tag_a [NC];
    logic [1:0]  msk_a [NC];
    logic [15:0] dq_a  [NC];
    int          lat_a [NC + 1];

    function automatic logic [31:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic logic iss_at(int i);
        return (i >= 0) ? iss_a[i] : 1'b0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, n);
        end
    endtask

    task automatic check_beat(input string req);
        int b, c;
        logic       ev;
        logic [3:0] et;
        logic [1:0] em, eb;
        logic [15:0] ed;
        if (n < 1) return;
        b  = n - 1;
        ev = 1'b0;
        et = '0;
        if (b - 2 >= 0 && iss_a[b-2] && lat_a[b-2] == 2) begin ev = 1'b1; c = b - 2; et = tag_a[c]; end
        if (b - 3 >= 0 && iss_a[b-3] && lat_a[b-3] == 3) begin ev = 1'b1; c = b - 3; et = tag_a[c]; end
        em = (b - 2 >= 0) ? msk_a[b-2] : 2'b00;
        eb = ev ? ~em : 2'b00;
        ed = {eb[1] ? dq_a[b][15:8] : 8'h00, eb[0] ? dq_a[b][7:0] : 8'h00};
        chk(req, {31'b0, cap_valid}, {31'b0, ev});
        chk(req, {28'b0, cap_tag}, {28'b0, et});
        chk("R5", {30'b0, cap_byte_vld}, {30'b0, eb});
        if (ev && em != 2'b00) chk("R6", {16'b0, cap_data}, {16'b0, ed});
        else                   chk("R7", {16'b0, cap_data}, {16'b0, ed});
    endtask

    task automatic step(input logic i, input logic [3:0] t, input logic cfg,
                        input logic [1:0] m, input logic [15:0] d, input string req);
        @(negedge clk);
        check_beat(req);
        rd_issue = i; rd_tag = t; lat_cfg = cfg; dqm = m; dq_in = d;
        iss_a[n] = i; tag_a[n] = t; msk_a[n] = m; dq_a[n] = d;
        if (!i && !iss_at(n-1) && !iss_at(n-2) && !iss_at(n-3))
            lat_a[n+1] = cfg ? 3 : 2;
        else
            lat_a[n+1] = lat_a[n];
        n++;
    endtask

    task automatic rnd_step(input logic cfg, input int dens, input string req);
        logic [31:0] r;
        r = rnd();
        step((r[7:0] < dens[7:0]), r[11:8], cfg, r[13:12] & {r[14], r[15]}, r[31:16], req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin : stim
        // R1: outputs stay zero in reset despite activity
        repeat (3) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            rd_issue = 1'b1; rd_tag = 4'(k + 1); dqm = 2'(k); dq_in = 16'hA5A5 ^ 16'(k);
            @(negedge clk);
            chk("R1", {31'b0, cap_valid}, 32'h0);
            chk("R1", {30'b0, cap_byte_vld}, 32'h0);
            chk("R1", {16'b0, cap_data}, 32'h0);
            chk("R1", {28'b0, cap_tag}, 32'h0);
        end
        rd_issue = 1'b0; dqm = '0; dq_in = '0; rd_tag = '0; lat_cfg = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        lat_a[0] = 2;
        // first cycle after reset: checked by step's beat model (all zero) under R1
        step(1'b0, 4'h0, 1'b0, 2'b00, 16'hFFFF, "R1");
        step(1'b0, 4'h0, 1'b0, 2'b11, 16'h1234, "R1");

        // R2: random traffic, latency two
        for (int k = 0; k < 400; k++) rnd_step(1'b0, 140, "R2");
        // switch to latency three after an idle gap (R8)
        for (int k = 0; k < 6; k++) step(1'b0, 4'h0, 1'b1, 2'b00, 16'(k), "R8");
        // R3: random traffic, latency three
        for (int k = 0; k < 400; k++) rnd_step(1'b1, 140, "R3");
        // R4: a read on every clock at latency three
        for (int k = 0; k < 100; k++) step(1'b1, 4'(k), 1'b1, 2'(k % 4), 16'(k * 97), "R4");
        // R8: setting flips while reads keep flowing: old latency stays in effect
        for (int k = 0; k < 60; k++) step(1'b1, 4'(k + 3), 1'b0, 2'(k % 3), 16'(k * 31 + 5), "R8");
        for (int k = 0; k < 6; k++) step(1'b0, 4'h0, 1'b0, 2'b00, 16'hBEEF, "R8");
        // R4: a read on every clock at latency two
        for (int k = 0; k < 100; k++) step(1'b1, 4'(k + 7), 1'b0, 2'((k / 2) % 4), 16'(k * 53), "R4");
        // R8: toggle setting every cycle during mixed traffic
        for (int k = 0; k < 300; k++) rnd_step(1'(k % 2), 60, "R8");
        // R9: no reads, bus and mask busy
        for (int k = 0; k < 40; k++) step(1'b0, 4'hF, 1'b0, 2'(k % 4), 16'(rnd()), "R9");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule